// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Increment

This block is a slave on a two-wire serial bus, the kind used in I2C. It sits in front of a file of 128 eight-bit registers. It watches the clock line and the open-drain data line, oversampled on the system clock. It recognises start, repeated start and stop conditions, and it answers to one of two device addresses. The address is picked by a strap pin that is sampled while reset is held.

A master writes by sending the device address, a register index and one or more data bytes. It reads by first writing the index, then issuing a repeated start with the read bit set, and then clocking the data out. One control bit in the register file chooses the addressing mode. When the bit is set, the pointer steps forward after every byte in both directions. When the bit is clear, a transaction touches exactly one register.

The slave never drives the data line high. It only pulls the line low, through `sda_oe`, and it changes that drive only while the clock is low.

Top module: `twowire_regslave`

## Requirements
- R1: After reset the slave releases the data line. A start is the data line falling while the clock is high, and a stop is the data line rising while the clock is high. A stop always returns the slave to idle, with the data line released.
- R2: The first byte after a start carries the 7-bit device address in bits 7..1 and the direction bit in bit 0 (0 for write, 1 for read), MSB first. On a match the slave pulls the data line low for the ninth clock. On a mismatch it gives no acknowledge and ignores all traffic until the next start.
- R3: On a write, the slave acknowledges the register-index byte and the data byte, and the data lands in the indexed register. Bit 7 of the index byte is ignored. All registers reset to zero.
- R4: A read consists of a write of the index, a repeated start, and the device address with the read bit. The slave then returns the indexed register MSB first, until the master NACKs and stops.
- R5: The auto-increment control bit is bit 0 of register 0x40. When it is 1, successive data bytes in one write go to successive registers, and each byte is acknowledged.
- R6: With the control bit at 1, a read returns the indexed register and then successively higher registers for as long as the master acknowledges.
- R7: With the control bit at 0, only the first data byte of a write is stored and acknowledged. The next byte is NACKed and is not stored.
- R8: With the control bit at 0, every byte of a read repeats the same register.
- R9: The register pointer wraps from 127 to 0, for both writes and reads.
- R10: A start that comes anywhere other than idle or the first bit clock of a data byte aborts the transfer to idle, as does a stop in mid-byte. No partial byte is written.
- R11: The strap pin is sampled during reset. Low selects device address 0x3A and high selects 0x3B. The other address is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset; the address strap is sampled while it is low |
| addr_sel | input | 1 | Device address strap |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
A wrong state or bit count shows up at the ports within one byte. The acknowledge appears on the wrong clock or not at all, or the returned byte is shifted. A wrong pointer or a missed control bit only shows on a later read, so every write scenario ends by reading its registers back, including the neighbours that must stay untouched. The abort cases are checked the same way: the bytes that follow an aborted start must not be acknowledged, and the register they aimed at must keep its old value.

// File: rtl/twowire_regslave.sv
module twowire_regslave #(
  parameter int          AW          = 7,
  parameter logic [6:0]  DEV_ADDR_LO = 7'h3A,
  parameter logic [6:0]  DEV_ADDR_HI = 7'h3B,
  parameter logic [AW-1:0] CTRL_ADDR = 7'h40,
  parameter int          CONT_BIT    = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_sel,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [3:0] {IDLE, DEVA, DEVACK, REGA, REGACK, WDAT, WACK, RDAT, RACK} st_t;

  st_t          state;
  logic [2:0]   scl_q, sda_q;
  logic [3:0]   cnt;
  logic [7:0]   sh;
  logic [AW-1:0] ptr;
  logic         rw, first, oe, sel_q;
  logic [7:0]   mem [DEPTH];

  wire scl_s = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_p = sda_q[2];
  wire rise    = scl_s & ~scl_p;
  wire fall    = ~scl_s & scl_p;
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_p & sda_s;

  wire [6:0]    my_addr    = sel_q ? DEV_ADDR_HI : DEV_ADDR_LO;
  wire          cont       = mem[CTRL_ADDR][CONT_BIT];
  wire [AW-1:0] nptr       = cont ? ptr + 1'b1 : ptr;
  wire          restart_ok = (state == IDLE) || (state == WDAT && cnt == 4'd1);

  assign sda_oe = oe;

  always_ff @(posedge clk)
    if (!rst_n) sel_q <= addr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      state <= IDLE;
      cnt   <= '0;
      sh    <= '0;
      ptr   <= '0;
      rw    <= 1'b0;
      first <= 1'b0;
      oe    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (start_c) begin
        state <= restart_ok ? DEVA : IDLE;
        cnt   <= '0;
        oe    <= 1'b0;
      end else if (stop_c) begin
        state <= IDLE;
        oe    <= 1'b0;
      end else if (rise) begin
        case (state)
          DEVA, REGA, WDAT:
            if (cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end
          RDAT: cnt <= cnt + 1'b1;
          RACK: if (sda_s) state <= IDLE;
          default: ;
        endcase
      end else if (fall) begin
        case (state)
          DEVA:
            if (cnt == 4'd8) begin
              if (sh[7:1] == my_addr) begin
                rw    <= sh[0];
                oe    <= 1'b1;
                state <= DEVACK;
              end else begin
                state <= IDLE;
              end
            end
          DEVACK: begin
            cnt <= '0;
            if (rw) begin
              sh    <= mem[ptr];
              oe    <= ~mem[ptr][7];
              state <= RDAT;
            end else begin
              oe    <= 1'b0;
              state <= REGA;
            end
          end
          REGA:
            if (cnt == 4'd8) begin
              ptr   <= sh[AW-1:0];
              oe    <= 1'b1;
              state <= REGACK;
            end
          REGACK: begin
            oe    <= 1'b0;
            cnt   <= '0;
            first <= 1'b1;
            state <= WDAT;
          end
          WDAT:
            if (cnt == 4'd8) begin
              if (cont || first) begin
                mem[ptr] <= sh;
                ptr      <= nptr;
                first    <= 1'b0;
                oe       <= 1'b1;
                state    <= WACK;
              end else begin
                state <= IDLE;
              end
            end
          WACK: begin
            oe    <= 1'b0;
            cnt   <= '0;
            state <= WDAT;
          end
          RDAT:
            if (cnt == 4'd8) begin
              oe    <= 1'b0;
              state <= RACK;
            end else begin
              sh <= {sh[6:0], 1'b0};
              oe <= ~sh[6];
            end
          RACK: begin
            ptr   <= nptr;
            sh    <= mem[nptr];
            oe    <= ~mem[nptr][7];
            cnt   <= '0;
            state <= RDAT;
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state == IDLE && !sda_oe));

  // R1
  drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R2
  no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && state == DEVA && cnt == 4'd8 && sh[7:1] != my_addr) |=> (state == IDLE && !sda_oe));

  // R7
  extra_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_c && !stop_c && fall && state == WDAT && cnt == 4'd8 && !cont && !first) |=> !sda_oe);

  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_c && !stop_c && fall && state == WDAT && cnt == 4'd8 && cont && ptr == '1) |=> ptr == '0);

  // R10
  abort_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && !restart_ok) |=> (state == IDLE && !sda_oe));
endmodule

// File: tb/twowire_regslave_test.sv
module twowire_regslave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda;
  int total = 0;
  int bad = 0;

  assign sda = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  twowire_regslave uut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
    .scl_i(m_scl), .sda_i(sda), .sda_oe(sda_oe)
  );

  localparam logic [6:0] DA = 7'h3A;
  localparam logic [6:0] DB = 7'h3B;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset(input logic strap);
    addr_sel = strap;
    rst_n = 1'b0;
    m_scl = 1'b1;
    m_sda = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic m_start;
    m_sda = 1'b1; hw; m_scl = 1'b1; hw; m_sda = 1'b0; hw; m_scl = 1'b0; hw;
  endtask

  task automatic m_stop;
    m_sda = 1'b0; hw; m_scl = 1'b1; hw; m_sda = 1'b1; hw;
  endtask

  task automatic m_bit(input logic b);
    m_sda = b; hw; m_scl = 1'b1; hw; m_scl = 1'b0; hw;
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    m_sda = 1'b1; hw; m_scl = 1'b1; hw;
    ack = ~sda;
    m_scl = 1'b0; hw;
  endtask

  task automatic m_rbyte(input logic ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hw; m_scl = 1'b1; hw;
      d = {d[6:0], sda};
      m_scl = 1'b0;
    end
    hw; m_sda = ~ack; hw; m_scl = 1'b1; hw; m_scl = 1'b0; hw; m_sda = 1'b1;
  endtask

  task automatic wr(input logic [6:0] dev, input logic [7:0] ra, input logic [23:0] d,
                    input int n, output logic [4:0] av);
    logic a;
    av = '0;
    m_start;
    m_wbyte({dev, 1'b0}, a); av[0] = a;
    m_wbyte(ra, a); av[1] = a;
    for (int i = 0; i < n; i++) begin
      m_wbyte(d[8*i +: 8], a);
      av[2+i] = a;
    end
    m_stop;
  endtask

  task automatic rd(input logic [6:0] dev, input logic [7:0] ra, input int n,
                    output logic [23:0] r);
    logic a;
    logic [7:0] b;
    r = '0;
    m_start;
    m_wbyte({dev, 1'b0}, a);
    m_wbyte(ra, a);
    m_start;
    m_wbyte({dev, 1'b1}, a);
    for (int i = 0; i < n; i++) begin
      m_rbyte(i != n - 1, b);
      r[8*i +: 8] = b;
    end
    m_stop;
  endtask

  task automatic t_reset;
    logic [23:0] r;
    chk("R1 released after reset", sda_oe, 0);
    rd(DA, 8'h05, 1, r);
    chk("R3 reset value", r[7:0], 8'h00);
  endtask

  task automatic t_single;
    logic [4:0] av;
    logic [23:0] r;
    wr(DA, 8'h05, 24'h0000C5, 1, av);
    chk("R2 R3 single write acks", av, 5'b00111);
    rd(DA, 8'h05, 1, r);
    chk("R4 single read MSB first", r[7:0], 8'hC5);
  endtask

  task automatic t_nocont;
    logic [4:0] av;
    logic [23:0] r;
    wr(DA, 8'h08, 24'h00C2C1, 2, av);
    chk("R7 second byte nacked", av, 5'b00111);
    rd(DA, 8'h09, 1, r);
    chk("R7 next register untouched", r[7:0], 8'h00);
    rd(DA, 8'h08, 2, r);
    chk("R8 repeated read", r[15:0], 16'hC1C1);
  endtask

  task automatic t_cont;
    logic [4:0] av;
    logic [23:0] r;
    wr(DA, 8'h40, 24'h000001, 1, av);
    chk("R5 enable auto increment", av, 5'b00111);
    wr(DA, 8'h10, 24'h332211, 3, av);
    chk("R5 burst write acks", av, 5'b11111);
    rd(DA, 8'h11, 1, r);
    chk("R5 middle register", r[7:0], 8'h22);
    rd(DA, 8'h10, 3, r);
    chk("R6 burst read", r, 24'h332211);
  endtask

  task automatic t_wrap;
    logic [4:0] av;
    logic [23:0] r;
    wr(DA, 8'h7F, 24'h007EE7, 2, av);
    chk("R9 wrap write acks", av, 5'b01111);
    rd(DA, 8'h00, 1, r);
    chk("R9 wrapped write reached 0", r[7:0], 8'h7E);
    rd(DA, 8'h7F, 2, r);
    chk("R9 wrapped read", r[15:0], 16'h7EE7);
  endtask

  task automatic t_mismatch;
    logic a;
    logic [23:0] r;
    m_start;
    m_wbyte({7'h21, 1'b0}, a);
    chk("R2 wrong address no ack", a, 0);
    m_wbyte(8'h05, a);
    chk("R2 ignored until start", a, 0);
    m_wbyte(8'h99, a);
    m_stop;
    rd(DA, 8'h05, 1, r);
    chk("R2 register unchanged", r[7:0], 8'hC5);
  endtask

  task automatic t_abort;
    logic a;
    logic [23:0] r;
    m_start;
    m_wbyte({DA, 1'b0}, a);
    m_wbyte(8'h05, a);
    m_bit(1'b0); m_bit(1'b1); m_bit(1'b1); m_bit(1'b0);
    m_start;
    m_wbyte(8'hFF, a);
    chk("R10 no ack after aborting start", a, 0);
    m_stop;
    rd(DA, 8'h05, 1, r);
    chk("R10 start abort keeps register", r[7:0], 8'hC5);
    m_start;
    m_wbyte({DA, 1'b0}, a);
    m_wbyte(8'h06, a);
    m_bit(1'b1); m_bit(1'b0); m_bit(1'b1);
    m_stop;
    chk("R1 released after stop", sda_oe, 0);
    rd(DA, 8'h06, 1, r);
    chk("R10 stop abort keeps register", r[7:0], 8'h00);
  endtask

  task automatic t_strap;
    logic [4:0] av;
    logic [23:0] r;
    do_reset(1'b1);
    wr(DA, 8'h05, 24'h00003C, 1, av);
    chk("R11 low address rejected", av[0], 0);
    wr(DB, 8'h05, 24'h00003C, 1, av);
    chk("R11 high address acks", av, 5'b00111);
    rd(DB, 8'h05, 1, r);
    chk("R11 readback on high address", r[7:0], 8'h3C);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    t_reset;
    t_single;
    t_nocont;
    t_cont;
    t_wrap;
    t_mismatch;
    t_abort;
    t_strap;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule